// File: doc/BRIEF.md
# Watchdog Timer with Shaped Reset Output

This block is a software-programmed watchdog. Firmware sets a countdown in whole time units, either seconds or minutes, and must reload it before it runs out. If the count reaches zero, the block latches a timeout flag and drives a reset output. The output either stays asserted until firmware responds or fires as a pulse of fixed length. Its polarity can be chosen to suit the reset network it drives.

Firmware reaches the block through a small register port with two registers, a control register and a time register. Each write to the time register reloads the count and also restarts the sub-unit timebase, so the write acts as the kick. The timebase divides the clock into millisecond ticks using a clocks-per-millisecond parameter. Seconds and minutes are built from those ticks using parameters, which allows a simulation to shrink real time.

Top module: `wdog_rst`

## Requirements
- R1: After reset, both registers read 0x00 and `wdt_rst_out` is 1 (the output is inactive and active-low).
- R2: `reg_addr`=0 selects control and `reg_addr`=1 selects time. Control bit 7 always reads 0, whatever value is written to it.
- R3: A write to the time register loads the 8-bit count and restarts the unit timebase. Reading the time register returns the remaining count. A reload made before expiry postpones the timeout by a full new interval, counted from the write.
- R4: Counting is enabled by control bit 5. While that bit is 0, the count holds its value and the timebase stays cleared. When the bit is set again, a full unit elapses before the next decrement.
- R5: Control bit 3 = 0 selects seconds (MS_PER_SEC millisecond ticks per unit). For a count of N, expiry occurs exactly N·MS_PER_SEC·MS_CLKS clocks after the edge that loaded it.
- R6: Control bit 3 = 1 selects minutes (SEC_PER_MIN seconds per unit). Expiry timing follows the same rule as R5, with the longer unit.
- R7: Control bit 6 is set by expiry. Writing 1 to it clears it. Writing 0 to it leaves it unchanged.
- R8: A count of 0 never expires.
- R9: Control bit 4 = 0 selects level mode. In this mode the output is asserted while the status bit is set and counting is enabled. Clearing the status bit or disabling counting releases it.
- R10: Control bit 4 = 1 selects pulse mode. In this mode the output is asserted for exactly W·MS_CLKS clocks, starting with expiry. W is selected by control bits 1:0: 0 gives 1, 1 gives 25, 2 gives 125, and 3 gives 5·MS_PER_SEC.
- R11: Control bit 2 = 1 makes the output active high. Control bit 2 = 0 makes it active low.
- R12: After expiry the count stays at 0 and does not expire again until it is reloaded. In pulse mode, the status bit stays set after the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 1 | Register select: 0 control, 1 time |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| wdt_rst_out | output | 1 | Shaped reset output |

## Verification
An error in the unit prescaler or the countdown shows at the output as an expiry that comes one or more clocks early or late, and a wrong reload shows there as early or late expiry in the same way. For this reason the bench samples the output exactly one clock before and one clock after the computed expiry edge. A pulse-length counter that is off by one shifts the release edge, which is checked on both sides of the boundary. A status flag that is lost, or cleared by mistake, changes the level-mode output in the next cycle and is also visible in the control read-back.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned TIME_W = 8;

    typedef enum logic {
        REG_CTRL = 1'b0,
        REG_TIME = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic       rsv;
        logic       sts;
        logic       run;
        logic       pulse_mode;
        logic       minutes;
        logic       act_high;
        logic [1:0] pw_sel;
    } ctrl_t;

    // pulse width in millisecond ticks for a width select code
    function automatic int unsigned pulse_ms(input logic [1:0] sel,
                                             input int unsigned ms_per_sec);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 25;
            2'd2:    return 125;
            default: return 5 * ms_per_sec;
        endcase
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              addr,
    input  logic [7:0]        wdata,
    input  logic              we,
    input  logic              expire,
    input  logic [TIME_W-1:0] cnt_val,
    output logic [7:0]        rdata,
    output logic              time_load,
    output logic              run,
    output logic              sts,
    output logic              pulse_mode,
    output logic              minutes,
    output logic              act_high,
    output logic [1:0]        pw_sel
);
    ctrl_t ctrl_q;
    ctrl_t wr;
    logic  ctrl_wr;

    assign wr        = ctrl_t'(wdata);
    assign ctrl_wr   = we && (reg_sel_e'(addr) == REG_CTRL);
    assign time_load = we && (reg_sel_e'(addr) == REG_TIME);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q.rsv        <= wr.rsv & 1'b0;
                ctrl_q.run        <= wr.run;
                ctrl_q.pulse_mode <= wr.pulse_mode;
                ctrl_q.minutes    <= wr.minutes;
                ctrl_q.act_high   <= wr.act_high;
                ctrl_q.pw_sel     <= wr.pw_sel;
                if (wr.sts) ctrl_q.sts <= 1'b0;
            end
            if (expire) ctrl_q.sts <= 1'b1;
        end
    end

    assign rdata      = (reg_sel_e'(addr) == REG_CTRL) ? 8'(ctrl_q) : 8'(cnt_val);
    assign run        = ctrl_q.run;
    assign sts        = ctrl_q.sts;
    assign pulse_mode = ctrl_q.pulse_mode;
    assign minutes    = ctrl_q.minutes;
    assign act_high   = ctrl_q.act_high;
    assign pw_sel     = ctrl_q.pw_sel;

    // R7: expiry always leaves the flag set
    a_r7_sts_set: assert property (@(posedge clk) disable iff (rst)
        expire |=> ctrl_q.sts);

    // R7: a write of 1 clears it when no expiry competes
    a_r7_w1c: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wdata[6] && !expire) |=> !ctrl_q.sts);

endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
    parameter int unsigned MS_CLKS     = 50000,
    parameter int unsigned MS_PER_SEC  = 1000,
    parameter int unsigned SEC_PER_MIN = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic minutes,
    input  logic kick,
    output logic unit_tick
);
    localparam int unsigned MS_W     = (MS_CLKS > 1) ? $clog2(MS_CLKS) : 1;
    localparam int unsigned UNIT_MAX = MS_PER_SEC * SEC_PER_MIN;
    localparam int unsigned UW       = $clog2(UNIT_MAX + 1);

    logic [MS_W-1:0] ms_q;
    logic [UW-1:0]   u_q;
    logic [UW-1:0]   unit_last;
    logic            ms_tick;

    assign unit_last = minutes ? UW'(UNIT_MAX - 1) : UW'(MS_PER_SEC - 1);
    assign ms_tick   = run && (ms_q == MS_W'(MS_CLKS - 1));
    assign unit_tick = ms_tick && (u_q >= unit_last);

    always_ff @(posedge clk) begin
        if (rst || kick || !run) begin
            ms_q <= '0;
            u_q  <= '0;
        end else begin
            ms_q <= ms_tick ? '0 : ms_q + 1'b1;
            if (ms_tick) u_q <= unit_tick ? '0 : u_q + 1'b1;
        end
    end

    // R4: a stopped timebase stays cleared
    a_r4_idle_clear: assert property (@(posedge clk) disable iff (rst)
        !run |=> (ms_q == '0) && (u_q == '0));

endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              unit_tick,
    input  logic              load,
    input  logic [TIME_W-1:0] load_val,
    output logic [TIME_W-1:0] cnt_q,
    output logic              expire
);
    logic step;

    assign step   = run && unit_tick && (cnt_q != '0) && !load;
    assign expire = step && (cnt_q == TIME_W'(1));

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (step) cnt_q <= cnt_q - 1'b1;
    end

    // R3: a load takes the written value
    a_r3_load: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt_q == $past(load_val));

    // R4: disabled count holds
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(cnt_q));

    // R12: zero is sticky until reloaded
    a_r12_floor: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !load) |=> cnt_q == '0);

endmodule

// File: rtl/wdog_shaper.sv
module wdog_shaper
    import wdog_pkg::*;
#(
    parameter int unsigned MS_CLKS    = 50000,
    parameter int unsigned MS_PER_SEC = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       expire,
    input  logic       sts,
    input  logic       run,
    input  logic       pulse_mode,
    input  logic       act_high,
    input  logic [1:0] pw_sel,
    output logic       rst_out
);
    localparam int unsigned PW_MS_MAX = (5 * MS_PER_SEC > 125) ? 5 * MS_PER_SEC : 125;
    localparam int unsigned PW_MAX    = PW_MS_MAX * MS_CLKS;
    localparam int unsigned PWW       = $clog2(PW_MAX + 1);

    logic [PWW-1:0] width_clks;
    logic [PWW-1:0] pw_q;
    logic           active_q;
    logic           asserted;

    assign width_clks = PWW'(pulse_ms(pw_sel, MS_PER_SEC) * MS_CLKS);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            pw_q     <= '0;
        end else if (expire) begin
            active_q <= 1'b1;
            pw_q     <= width_clks - 1'b1;
        end else if (active_q) begin
            if (pw_q == '0) active_q <= 1'b0;
            else            pw_q     <= pw_q - 1'b1;
        end
    end

    assign asserted = pulse_mode ? active_q : (sts && run);
    assign rst_out  = act_high ? asserted : !asserted;

    // R10: pulse holds while width remains
    a_r10_pulse_hold: assert property (@(posedge clk) disable iff (rst)
        (active_q && pw_q != '0 && !expire) |=> active_q);

    // R10: pulse ends once width is used
    a_r10_pulse_end: assert property (@(posedge clk) disable iff (rst)
        (active_q && pw_q == '0 && !expire) |=> !active_q);

endmodule

// File: rtl/wdog_rst.sv
module wdog_rst
    import wdog_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned MS_CLKS     = CLK_HZ / 1000,
    parameter int unsigned MS_PER_SEC  = 1000,
    parameter int unsigned SEC_PER_MIN = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       reg_we,
    output logic [7:0] reg_rdata,
    output logic       wdt_rst_out
);
    logic              time_load;
    logic              run;
    logic              sts;
    logic              pulse_mode;
    logic              minutes;
    logic              act_high;
    logic [1:0]        pw_sel;
    logic              unit_tick;
    logic              expire;
    logic [TIME_W-1:0] cnt;

    wdog_regs u_regs (
        .clk(clk), .rst(rst), .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
        .expire(expire), .cnt_val(cnt), .rdata(reg_rdata), .time_load(time_load),
        .run(run), .sts(sts), .pulse_mode(pulse_mode), .minutes(minutes),
        .act_high(act_high), .pw_sel(pw_sel)
    );

    wdog_timebase #(
        .MS_CLKS(MS_CLKS), .MS_PER_SEC(MS_PER_SEC), .SEC_PER_MIN(SEC_PER_MIN)
    ) u_timebase (
        .clk(clk), .rst(rst), .run(run), .minutes(minutes),
        .kick(time_load), .unit_tick(unit_tick)
    );

    wdog_count u_count (
        .clk(clk), .rst(rst), .run(run), .unit_tick(unit_tick),
        .load(time_load), .load_val(reg_wdata), .cnt_q(cnt), .expire(expire)
    );

    wdog_shaper #(
        .MS_CLKS(MS_CLKS), .MS_PER_SEC(MS_PER_SEC)
    ) u_shaper (
        .clk(clk), .rst(rst), .expire(expire), .sts(sts), .run(run),
        .pulse_mode(pulse_mode), .act_high(act_high), .pw_sel(pw_sel),
        .rst_out(wdt_rst_out)
    );

endmodule

// File: tb/wdog_rst_bench.sv
module wdog_rst_bench;
    localparam time         CLK_PERIOD = 10ns;
    localparam int unsigned MS_CLKS    = 2;
    localparam int unsigned MSPS       = 10;
    localparam int unsigned SPM        = 60;
    localparam int unsigned SEC_CLKS   = MS_CLKS * MSPS;
    localparam int unsigned MIN_CLKS   = SEC_CLKS * SPM;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic       wdt_rst_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdog_rst #(.MS_CLKS(MS_CLKS), .MS_PER_SEC(MSPS), .SEC_PER_MIN(SPM)) u_wdog_rst (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .wdt_rst_out(wdt_rst_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(1'b0, v); chk("R1 ctrl", v, 0);
        rd(1'b1, v); chk("R1 time", v, 0);
        chk("R1 out", wdt_rst_out, 1);
    endtask

    task automatic t_reserved();
        logic [7:0] v;
        wr(1'b0, 8'h80);
        rd(1'b0, v); chk("R2 bit7", v, 0);
    endtask

    task automatic t_level();
        logic [7:0] v;
        wr(1'b0, 8'h20);
        wr(1'b1, 8'd3);
        wait_clks(3 * SEC_CLKS - 1);
        chk("R5 before", wdt_rst_out, 1);
        rd(1'b0, v); chk("R7 not set", v, 8'h20);
        wait_clks(1);
        chk("R5 at expiry", wdt_rst_out, 0);
        rd(1'b0, v); chk("R7 set", v, 8'h60);
        wait_clks(50);
        chk("R9 level held", wdt_rst_out, 0);
        wr(1'b0, 8'h20);
        rd(1'b0, v); chk("R7 write0 keeps", v, 8'h60);
        chk("R9 still held", wdt_rst_out, 0);
        wr(1'b0, 8'h60);
        rd(1'b0, v); chk("R7 w1c", v, 8'h20);
        chk("R9 released", wdt_rst_out, 1);
        wait_clks(100);
        chk("R12 no re-expiry", wdt_rst_out, 1);
        rd(1'b1, v); chk("R12 count zero", v, 0);
    endtask

    task automatic t_kick();
        wr(1'b1, 8'd2);
        wait_clks(30);
        wr(1'b1, 8'd2);
        wait_clks(2 * SEC_CLKS - 1);
        chk("R3 kick delays", wdt_rst_out, 1);
        wait_clks(1);
        chk("R3 kick expiry", wdt_rst_out, 0);
        wr(1'b0, 8'h40);
        chk("R9 disable release", wdt_rst_out, 1);
    endtask

    task automatic t_hold();
        logic [7:0] v;
        wr(1'b0, 8'h20);
        wr(1'b1, 8'd5);
        wait_clks(30);
        wr(1'b0, 8'h00);
        rd(1'b1, v); chk("R4 count after one unit", v, 4);
        wait_clks(200);
        rd(1'b1, v); chk("R4 held", v, 4);
        chk("R4 no expiry", wdt_rst_out, 1);
        wr(1'b0, 8'h20);
        wait_clks(4 * SEC_CLKS - 1);
        chk("R4 resume before", wdt_rst_out, 1);
        wait_clks(1);
        chk("R4 resume expiry", wdt_rst_out, 0);
        wr(1'b0, 8'h40);
    endtask

    task automatic t_zero();
        logic [7:0] v;
        wr(1'b0, 8'h20);
        wr(1'b1, 8'd0);
        wait_clks(300);
        chk("R8 out", wdt_rst_out, 1);
        rd(1'b0, v); chk("R8 status", v, 8'h20);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_minute();
        wr(1'b0, 8'h28);
        wr(1'b1, 8'd1);
        wait_clks(MIN_CLKS - 1);
        chk("R6 before", wdt_rst_out, 1);
        wait_clks(1);
        chk("R6 at expiry", wdt_rst_out, 0);
        wr(1'b0, 8'h40);
    endtask

    task automatic t_pulse();
        logic [7:0] v;
        for (int s = 0; s < 4; s++) begin
            int w;
            w = (s == 0) ? 1 : (s == 1) ? 25 : (s == 2) ? 125 : 5 * MSPS;
            wr(1'b0, 8'(8'h30 | s));
            wr(1'b1, 8'd1);
            wait_clks(SEC_CLKS - 1);
            chk("R10 idle", wdt_rst_out, 1);
            wait_clks(1);
            chk("R10 start", wdt_rst_out, 0);
            wait_clks(w * MS_CLKS - 1);
            chk("R10 last cycle", wdt_rst_out, 0);
            wait_clks(1);
            chk("R10 released", wdt_rst_out, 1);
            rd(1'b0, v); chk("R12 status kept", v[6], 1);
            wr(1'b0, 8'h40);
        end
    endtask

    task automatic t_polarity();
        wr(1'b0, 8'h24);
        chk("R11 idle high-active", wdt_rst_out, 0);
        wr(1'b1, 8'd1);
        wait_clks(SEC_CLKS - 1);
        chk("R11 before", wdt_rst_out, 0);
        wait_clks(1);
        chk("R11 asserted high", wdt_rst_out, 1);
        wr(1'b0, 8'h44);
        chk("R11 released low", wdt_rst_out, 0);
        wr(1'b0, 8'h00);
        chk("R11 back to low-active", wdt_rst_out, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        wait_clks(3);
        rst = 1'b0;
        wait_clks(1);
        t_reset();
        t_reserved();
        t_level();
        t_kick();
        t_hold();
        t_zero();
        t_minute();
        t_pulse();
        t_polarity();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule